// File: doc/BRIEF.md
# Engine Reset and Scrub Sequencer

This block takes an embedded microcontroller engine through a hardware reset and waits until the engine's local memories have been scrubbed. A single start pulse begins the run. The sequencer first gives the engine a bounded time to signal that it is ready for reset. If that time runs out it continues anyway, because some engines never raise the ready flag. It then drives the engine reset output high for a fixed hold time and releases it. After that it waits for the scrub-complete status.

When scrubbing finishes, the sequencer requests a core selection with a one-cycle pulse and waits for scrub-complete a second time, using the same bound. If that wait also succeeds, it writes an identification word to the engine and then pulses done. A scrub wait that runs out ends the run with an error pulse. All time limits are counted in pulses of a microsecond tick input, so a testbench can shorten them by ticking on every clock.

Top module: `eng_reset_seq`

## Requirements
- R1: While the synchronous active-high reset is high, and in the cycle after it, the engine reset output, core-select request, identification write, done and error outputs are all low.
- R2: An accepted start pulse begins the ready wait. If ready is already high, the engine reset output rises in the second cycle after the start pulse was sampled.
- R3: If ready never rises, the engine reset output rises once RDY_WAIT_US ticks have been counted in the ready wait. With a tick on every cycle, that is RDY_WAIT_US cycles later than in R2. No error is reported, and the run completes normally.
- R4: The engine reset output stays high until RST_HOLD_US ticks have been counted, so it is high for exactly RST_HOLD_US+1 cycles when a tick comes on every cycle. While the tick stays low it remains high indefinitely.
- R5: After the reset output falls, the block waits for scrub-complete. When scrub-complete is seen, the core-select request goes high for exactly one cycle.
- R6: If scrub-complete does not arrive within SCRUB_WAIT_US ticks in the first scrub wait, the error output pulses for one cycle. No core-select request, identification write or done follows, and the block returns to idle.
- R7: After the core-select request, a second scrub wait with the same bound follows. If it times out, the result is a single error pulse with no identification write and no done.
- R8: When the second scrub wait succeeds, the identification write strobe pulses for one cycle and carries the ID value that was sampled when the run was started. Done pulses in the very next cycle.
- R9: A start pulse that arrives while a run is in progress is ignored. It does not restart the reset hold and does not cause a second done.
- R10: Raising the synchronous reset in the middle of a run drops the engine reset output at the next clock edge. A later start pulse then runs a complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; ignored while a run is in progress |
| tick_i | input | 1 | One-cycle pulse per microsecond of timeout counting |
| rst_ready_i | input | 1 | Engine reports that it is ready to be reset |
| scrub_done_i | input | 1 | Engine memory scrubbing complete |
| chip_id_i | input | ID_W | Identification word; sampled at start |
| eng_rst_o | output | 1 | Engine reset, active high |
| core_sel_o | output | 1 | One-cycle core-select request |
| id_wr_o | output | 1 | One-cycle write strobe for the identification word |
| id_data_o | output | ID_W | Identification word to write |
| done_o | output | 1 | One-cycle pulse on success |
| err_o | output | 1 | One-cycle pulse on scrub timeout |

## Verification
The hardest case to reach from the ports is a timeout in the second scrub wait. The first wait has to succeed and the second has to fail, which means the scrub status must fall in the very cycle after core-select is seen. The stimulus watches for the core-select pulse, which lasts one cycle, and drops scrub-complete right after it. The second wait then starts with the status already low. Holding the tick input low during the reset hold shows that the hold only advances on ticks. A start pulse injected mid-hold shows that busy runs are not restarted.

// File: rtl/eng_seq_pkg.sv
package eng_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_RDY,
    S_HOLD,
    S_SCRUB1,
    S_CSEL,
    S_SCRUB2,
    S_IDWR,
    S_DONE,
    S_ERR
  } seq_state_e;

  // Width needed to hold values 0..v
  function automatic int unsigned width_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Limit reached once the tick count has caught up with the bound
  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/eng_seq_timer.sv
module eng_seq_timer
  import eng_seq_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt;

  assign expired = limit_hit(32'(cnt), 32'(limit));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: count never moves backwards unless cleared
  a_r4_cnt_monotonic: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt >= $past(cnt));

  // R4: no tick, no progress
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/eng_seq_fsm.sv
module eng_seq_fsm
  import eng_seq_pkg::*;
#(
  parameter int unsigned CW            = 16,
  parameter int unsigned ID_W          = 32,
  parameter int unsigned RDY_WAIT_US   = 150,
  parameter int unsigned RST_HOLD_US   = 10,
  parameter int unsigned SCRUB_WAIT_US = 20000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            rst_ready_i,
  input  logic            scrub_done_i,
  input  logic [ID_W-1:0] chip_id_i,
  input  logic            tmr_expired,
  output logic            tmr_clr,
  output logic [CW-1:0]   tmr_limit,
  output logic            eng_rst_o,
  output logic            core_sel_o,
  output logic            id_wr_o,
  output logic [ID_W-1:0] id_data_o,
  output logic            done_o,
  output logic            err_o
);

  localparam logic [CW-1:0] RDY_LIM   = CW'(RDY_WAIT_US);
  localparam logic [CW-1:0] HOLD_LIM  = CW'(RST_HOLD_US);
  localparam logic [CW-1:0] SCRUB_LIM = CW'(SCRUB_WAIT_US);

  seq_state_e st, nxt;
  logic [ID_W-1:0] id_q;

  // Named events
  logic start_accept, scrub_ok, scrub_timeout;
  assign start_accept  = (st == S_IDLE) && start_i;
  assign scrub_ok      = ((st == S_SCRUB1) || (st == S_SCRUB2)) && scrub_done_i;
  assign scrub_timeout = ((st == S_SCRUB1) || (st == S_SCRUB2)) && !scrub_done_i && tmr_expired;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:     if (start_i) nxt = S_WAIT_RDY;
      S_WAIT_RDY: if (rst_ready_i || tmr_expired) nxt = S_HOLD;
      S_HOLD:     if (tmr_expired) nxt = S_SCRUB1;
      S_SCRUB1:   if (scrub_done_i) nxt = S_CSEL;
                  else if (tmr_expired) nxt = S_ERR;
      S_CSEL:     nxt = S_SCRUB2;
      S_SCRUB2:   if (scrub_done_i) nxt = S_IDWR;
                  else if (tmr_expired) nxt = S_ERR;
      S_IDWR:     nxt = S_DONE;
      S_DONE:     nxt = S_IDLE;
      S_ERR:      nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (st)
      S_WAIT_RDY: tmr_limit = RDY_LIM;
      S_HOLD:     tmr_limit = HOLD_LIM;
      default:    tmr_limit = SCRUB_LIM;
    endcase
  end

  assign tmr_clr = (nxt != st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      id_q <= '0;
    end else begin
      st <= nxt;
      if (start_accept) id_q <= chip_id_i;
    end
  end

  assign eng_rst_o  = (st == S_HOLD);
  assign core_sel_o = (st == S_CSEL);
  assign id_wr_o    = (st == S_IDWR);
  assign id_data_o  = id_q;
  assign done_o     = (st == S_DONE);
  assign err_o      = (st == S_ERR);

  // R2: reset only rises out of the ready wait
  a_r2_rst_after_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_rst_o) |-> $past(st) == S_WAIT_RDY);

  // R4: reset only released once the hold timer expired
  a_r4_release_on_expiry: assert property (@(posedge clk) disable iff (rst)
    ($fell(eng_rst_o) && !$past(rst)) |-> $past(tmr_expired));

  // R6 / R7: error only from a scrub wait that ran out
  a_r6_err_from_scrub: assert property (@(posedge clk) disable iff (rst)
    (err_o && !$past(rst)) |-> ($past(scrub_timeout)));

  a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  a_r5_csel_single: assert property (@(posedge clk) disable iff (rst)
    core_sel_o |=> !core_sel_o);

  // R8: done directly follows the ID write
  a_r8_done_after_id: assert property (@(posedge clk) disable iff (rst)
    (done_o && !$past(rst)) |-> $past(id_wr_o));

  // R9: start while busy never restarts the ready wait
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && st != S_WAIT_RDY && start_i) |=> st != S_WAIT_RDY);

  // R5: core-select only after a successful first scrub wait
  a_r5_csel_after_scrub: assert property (@(posedge clk) disable iff (rst)
    (core_sel_o && !$past(rst)) |-> ($past(scrub_ok) && $past(st) == S_SCRUB1));

endmodule

// File: rtl/eng_reset_seq.sv
module eng_reset_seq
  import eng_seq_pkg::*;
#(
  parameter int unsigned ID_W          = 32,
  parameter int unsigned RDY_WAIT_US   = 150,
  parameter int unsigned RST_HOLD_US   = 10,
  parameter int unsigned SCRUB_WAIT_US = 20000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            tick_i,
  input  logic            rst_ready_i,
  input  logic            scrub_done_i,
  input  logic [ID_W-1:0] chip_id_i,
  output logic            eng_rst_o,
  output logic            core_sel_o,
  output logic            id_wr_o,
  output logic [ID_W-1:0] id_data_o,
  output logic            done_o,
  output logic            err_o
);

  localparam int unsigned MAX_LIM = max3(RDY_WAIT_US, RST_HOLD_US, SCRUB_WAIT_US);
  localparam int unsigned CW      = width_for(MAX_LIM);

  logic          tmr_clr, tmr_expired;
  logic [CW-1:0] tmr_limit;

  eng_seq_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .tick    (tick_i),
    .limit   (tmr_limit),
    .expired (tmr_expired)
  );

  eng_seq_fsm #(
    .CW            (CW),
    .ID_W          (ID_W),
    .RDY_WAIT_US   (RDY_WAIT_US),
    .RST_HOLD_US   (RST_HOLD_US),
    .SCRUB_WAIT_US (SCRUB_WAIT_US)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .rst_ready_i  (rst_ready_i),
    .scrub_done_i (scrub_done_i),
    .chip_id_i    (chip_id_i),
    .tmr_expired  (tmr_expired),
    .tmr_clr      (tmr_clr),
    .tmr_limit    (tmr_limit),
    .eng_rst_o    (eng_rst_o),
    .core_sel_o   (core_sel_o),
    .id_wr_o      (id_wr_o),
    .id_data_o    (id_data_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  // R1: nothing active in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !(eng_rst_o || core_sel_o || id_wr_o || done_o || err_o));

endmodule

// File: tb/tb_eng_reset_seq.sv
module tb_eng_reset_seq;

  localparam int RDY   = 6;
  localparam int HOLD  = 4;
  localparam int SCRUB = 12;
  localparam int IDW   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, tick_i = 1'b1, rdy = 1'b0, scrub = 1'b0;
  logic [IDW-1:0] chip_id = '0;
  logic eng_rst, core_sel, id_wr, done, err;
  logic [IDW-1:0] id_data;

  always #2 clk = ~clk;

  eng_reset_seq #(.ID_W(IDW), .RDY_WAIT_US(RDY), .RST_HOLD_US(HOLD),
                  .SCRUB_WAIT_US(SCRUB)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
    .rst_ready_i(rdy), .scrub_done_i(scrub), .chip_id_i(chip_id),
    .eng_rst_o(eng_rst), .core_sel_o(core_sel), .id_wr_o(id_wr),
    .id_data_o(id_data), .done_o(done), .err_o(err));

  int checks = 0, fails = 0;
  int cyc = 0;
  int n_rst, n_csel, n_idwr, n_done, n_err;
  int first_rst, last_rst, csel_cyc, idwr_cyc, done_cyc;
  logic [IDW-1:0] id_seen;

  // Monitor samples at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (eng_rst) begin
      if (n_rst == 0) first_rst = cyc;
      last_rst = cyc;
      n_rst++;
    end
    if (core_sel) begin n_csel++; csel_cyc = cyc; end
    if (id_wr)    begin n_idwr++; idwr_cyc = cyc; id_seen = id_data; end
    if (done)     begin n_done++; done_cyc = cyc; end
    if (err)      n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic clear_mon();
    n_rst = 0; n_csel = 0; n_idwr = 0; n_done = 0; n_err = 0;
    first_rst = 0; last_rst = 0; csel_cyc = 0; idwr_cyc = 0; done_cyc = 0;
    id_seen = '0;
  endtask

  // Pulse start; returns cyc value at drive time
  task automatic pulse_start(output int cs);
    cs = cyc;
    start_i = 1'b1;
    step(1);
    start_i = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400; i++) begin
      if (n_done + n_err > 0) break;
      step(1);
    end
    step(3);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3);
    chk(!eng_rst && !core_sel && !id_wr && !done && !err, "R1 outputs low in reset", eng_rst, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!eng_rst && !core_sel && !id_wr && !done && !err, "R1 outputs low after reset", eng_rst, 0);
    step(1);
  endtask

  task automatic t_normal();
    int cs;
    clear_mon();
    rdy = 1'b1; scrub = 1'b1; tick_i = 1'b1;
    chip_id = 32'hA5A5_0001;
    pulse_start(cs);
    chip_id = 32'h0000_0000;
    wait_end();
    chk(first_rst - cs == 3, "R2 reset rise with ready high", first_rst - cs, 3);
    chk(n_rst == HOLD + 1, "R4 reset hold length", n_rst, HOLD + 1);
    chk(n_csel == 1, "R5 single core-select", n_csel, 1);
    chk(csel_cyc > last_rst, "R5 core-select after release", csel_cyc, last_rst + 1);
    chk(n_idwr == 1 && idwr_cyc > csel_cyc, "R8 id write after core-select", idwr_cyc, csel_cyc + 1);
    chk(id_seen == 32'hA5A5_0001, "R8 id value captured at start", id_seen, 32'hA5A5_0001);
    chk(n_done == 1 && done_cyc == idwr_cyc + 1, "R8 done follows id write", done_cyc, idwr_cyc + 1);
    chk(n_err == 0, "R8 no error on success", n_err, 0);
  endtask

  task automatic t_rdy_timeout();
    int cs;
    clear_mon();
    rdy = 1'b0; scrub = 1'b1;
    pulse_start(cs);
    wait_end();
    chk(first_rst - cs == RDY + 3, "R3 reset rise after ready timeout", first_rst - cs, RDY + 3);
    chk(n_err == 0 && n_done == 1, "R3 ready timeout is not an error", n_err, 0);
    rdy = 1'b1;
  endtask

  task automatic t_scrub1_fail();
    int cs;
    clear_mon();
    scrub = 1'b0;
    pulse_start(cs);
    wait_end();
    chk(n_err == 1, "R6 single error pulse", n_err, 1);
    chk(n_csel == 0 && n_idwr == 0 && n_done == 0, "R6 nothing after first scrub timeout",
        n_csel + n_idwr + n_done, 0);
    chk(!eng_rst, "R6 back to idle", eng_rst, 0);
  endtask

  task automatic t_scrub2_fail();
    int cs;
    clear_mon();
    scrub = 1'b1;
    pulse_start(cs);
    for (int i = 0; i < 100; i++) begin
      if (core_sel) break;
      step(1);
    end
    scrub = 1'b0;
    wait_end();
    chk(n_csel == 1 && n_err == 1, "R7 second scrub timeout gives error", n_err, 1);
    chk(n_idwr == 0 && n_done == 0, "R7 no id write or done", n_idwr + n_done, 0);
    scrub = 1'b1;
  endtask

  task automatic t_tick_stall();
    int cs;
    int held;
    clear_mon();
    pulse_start(cs);
    for (int i = 0; i < 20; i++) begin
      if (eng_rst) break;
      step(1);
    end
    tick_i = 1'b0;
    held = 0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (eng_rst) held++;
    end
    chk(held == 40, "R4 reset held while tick low", held, 40);
    tick_i = 1'b1;
    wait_end();
    chk(n_done == 1 && !eng_rst, "R4 completes once ticks resume", n_done, 1);
  endtask

  task automatic t_busy_start();
    int cs, dummy;
    clear_mon();
    pulse_start(cs);
    step(3);
    chk(eng_rst == 1'b1, "R9 in hold before extra start", eng_rst, 1);
    pulse_start(dummy);
    wait_end();
    step(20);
    chk(n_rst == HOLD + 1, "R9 hold not restarted", n_rst, HOLD + 1);
    chk(n_done == 1, "R9 single done", n_done, 1);
  endtask

  task automatic t_mid_reset();
    int cs;
    clear_mon();
    pulse_start(cs);
    step(3);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    @(negedge clk);
    chk(!eng_rst, "R10 engine reset dropped by sync reset", eng_rst, 0);
    step(1);
    clear_mon();
    pulse_start(cs);
    wait_end();
    chk(n_done == 1 && n_rst == HOLD + 1, "R10 full run after mid reset", n_done, 1);
  endtask

  initial begin
    clear_mon();
    t_reset();
    t_normal();
    t_rdy_timeout();
    t_scrub1_fail();
    t_scrub2_fail();
    t_tick_stall();
    t_busy_start();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #80000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule